// File: doc/BRIEF.md
# Host Address Aperture Map Decoder

This block sits beside an 8-bit host's 16-bit address bus and decides, for every host access, whether the expansion box should take that cycle. It does not compare the address against range registers. It looks the address up in an on-chip byte map. The byte found is the access class. Codes 0x00–0x0F pick one of sixteen memory apertures, and codes 0x10–0x1F mark video traffic. The idle code 0xFF means the box leaves the access alone, and so does any other code. The map is indexed by the top `IDX_W` bits of the address. With `IDX_W = 16` there is one entry per host address. The default of 12 gives one entry per 16-byte block, which keeps the elaborated store small.

A lookup is started by `host_strobe` with the address on `host_addr`. After two clock edges the block presents the class, the aperture number, and the active-low claim outputs. At 200 MHz that is 10 ns, well inside the roughly 45 ns a host allows before a claim must be driven. If either cartridge-present line is ever seen high, the block latches a cartridge mode that lasts until reset. In that mode, aperture classes are never claimed, and nothing at all is claimed in the cartridge windows 0x8000–0xBFFF.

A controller loads the map through a valid/ready write channel carrying an entry index and a data byte. The map has a single port and host lookups take priority. `cfg_ready` is therefore low in any cycle where `host_strobe` is high. The writer must hold `cfg_valid`, `cfg_index` and `cfg_data` steady until a cycle in which both `cfg_valid` and `cfg_ready` are high. Only that cycle commits the write.

Top module: `aam_decoder`

## Requirements
- R1: After reset, every map entry reads 0xFF. A lookup of an entry never written reports class 0xFF and no claim.
- R2: Each cycle with `host_strobe` high produces exactly one cycle of `res_valid` two clock edges later. `res_valid` is low at all other times.
- R3: Class 0x00–0x0F outside cartridge mode drives `claim_n` low, and `res_aperture` equals the class's low four bits. For every other class, `res_aperture` is 0.
- R4: Class 0x10–0x1F drives `claim_n` low in either mode, except where R8 forbids it.
- R5: Classes 0x20–0xFE behave like 0xFF. There is no claim, but `res_class` still reports the raw byte.
- R6: `rom_mask_n` is low exactly when `claim_n` is low and the looked-up address lies in 0xD800–0xDFFF.
- R7: Cartridge mode applies from the cycle in which `cart_rd4` or `cart_rd5` is first sampled high. `cart_mode` goes high one edge later and stays high until reset.
- R8: In cartridge mode, aperture classes 0x00–0x0F are never claimed, and no access to 0x8000–0xBFFF is claimed whatever its class.
- R9: `cfg_ready` equals the inverse of `host_strobe`. A write commits only when `cfg_valid` and `cfg_ready` are both high. A committed write is seen by any lookup strobed in a later cycle.
- R10: `claim_n` and `rom_mask_n` are high whenever `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 16 | Host address, sampled when `host_strobe` is high |
| host_strobe | input | 1 | Starts one lookup |
| cart_rd4 | input | 1 | Cartridge-present line for the lower window, active high |
| cart_rd5 | input | 1 | Cartridge-present line for the upper window, active high |
| cfg_valid | input | 1 | Map write request |
| cfg_ready | output | 1 | Map write can be taken this cycle |
| cfg_index | input | IDX_W | Map entry to write |
| cfg_data | input | 8 | New entry value |
| res_valid | output | 1 | Lookup result present |
| res_class | output | 8 | Raw map byte for the access |
| res_aperture | output | 4 | Aperture number for aperture classes, else 0 |
| claim_n | output | 1 | Active-low claim of the host cycle |
| rom_mask_n | output | 1 | Active-low claim inside 0xD800–0xDFFF |
| cart_mode | output | 1 | Cartridge mode latched |

## Verification
The hardest case is a write that is held off by a concurrent lookup and then read back straight away. The stimulus keeps `cfg_valid` high across a strobed cycle and strobes the same entry in the cycle right after the write commits. The second hard case is the moment cartridge mode begins. A single-cycle pulse on a cartridge line is driven together with a strobe into a cartridge window. Lookups that were written as aperture and video classes are then repeated, so the latched override can be compared against the earlier, unlatched results.

// File: rtl/aam_pkg.sv
package aam_pkg;
  localparam logic [7:0] CLASS_IDLE   = 8'hFF;
  localparam logic [3:0] GRP_APERTURE = 4'h0;
  localparam logic [3:0] GRP_VIDEO    = 4'h1;
  localparam logic [15:0] CART_LO     = 16'h8000;
  localparam logic [15:0] CART_HI     = 16'hBFFF;

  typedef struct packed {
    logic        valid;
    logic [15:0] addr;
    logic        cart;
  } look_t;
endpackage

// File: rtl/aam_map_store.sv
module aam_map_store #(
  parameter int IDX_W = 12,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data
);
  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] written;
  logic [7:0]       rd_raw;
  logic             rd_hit;

  // RAM body: no reset, the written flags stand in for the 0xFF fill.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_raw <= mem[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written <= '0;
      rd_hit  <= 1'b0;
    end else begin
      if (wr_en) written[wr_idx] <= 1'b1;
      if (rd_en) rd_hit <= written[rd_idx];
    end
  end

  assign rd_data = rd_hit ? rd_raw : aam_pkg::CLASS_IDLE;

  AST_SINGLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R9
endmodule

// File: rtl/aam_cart_latch.sv
module aam_cart_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic rd4,
  input  logic rd5,
  output logic cart_eff,
  output logic cart_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cart_q <= 1'b0;
    else if (rd4 || rd5) cart_q <= 1'b1;
  end

  assign cart_eff = cart_q | rd4 | rd5;

  AST_CART_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cart_q |=> cart_q); // R7
  AST_CART_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd4 || rd5) |=> cart_q); // R7
endmodule

// File: rtl/aam_classify.sv
module aam_classify #(
  parameter logic [15:0] MASK_LO = 16'hD800,
  parameter logic [15:0] MASK_HI = 16'hDFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  aam_pkg::look_t   s1,
  input  logic [7:0]       entry,
  output logic             res_valid,
  output logic [7:0]       res_class,
  output logic [3:0]       res_aperture,
  output logic             claim_n,
  output logic             rom_mask_n
);
  import aam_pkg::*;

  logic is_ap, is_vid, in_cart_win, in_mask, take;

  always_comb begin
    is_ap       = (entry[7:4] == GRP_APERTURE);
    is_vid      = (entry[7:4] == GRP_VIDEO);
    in_cart_win = (s1.addr >= CART_LO) && (s1.addr <= CART_HI);
    in_mask     = (s1.addr >= MASK_LO) && (s1.addr <= MASK_HI);
    take        = s1.valid
                  && ((is_ap && !s1.cart) || is_vid)
                  && !(s1.cart && in_cart_win);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_class    <= CLASS_IDLE;
      res_aperture <= '0;
      claim_n      <= 1'b1;
      rom_mask_n   <= 1'b1;
    end else begin
      res_valid    <= s1.valid;
      res_class    <= s1.valid ? entry : CLASS_IDLE;
      res_aperture <= (s1.valid && is_ap) ? entry[3:0] : 4'h0;
      claim_n      <= !take;
      rom_mask_n   <= !(take && in_mask);
    end
  end

  AST_CART_WINDOW_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (s1.valid && s1.cart && s1.addr[15:14] == 2'b10) |=> claim_n); // R8
  AST_IGNORED_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_class >= 8'h20) |-> claim_n); // R5
  AST_MASK_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_mask_n |-> !claim_n); // R6
endmodule

// File: rtl/aam_decoder.sv
module aam_decoder #(
  parameter int          ADDR_W  = 16,
  parameter int          IDX_W   = 12,
  parameter logic [15:0] MASK_LO = 16'hD800,
  parameter logic [15:0] MASK_HI = 16'hDFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      host_addr,
  input  logic             host_strobe,
  input  logic             cart_rd4,
  input  logic             cart_rd5,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [IDX_W-1:0] cfg_index,
  input  logic [7:0]       cfg_data,
  output logic             res_valid,
  output logic [7:0]       res_class,
  output logic [3:0]       res_aperture,
  output logic             claim_n,
  output logic             rom_mask_n,
  output logic             cart_mode
);
  import aam_pkg::*;

  logic             wr_en;
  logic             cart_eff;
  logic [IDX_W-1:0] look_idx;
  logic [7:0]       entry;
  look_t            s1;

  assign cfg_ready = !host_strobe;
  assign wr_en     = cfg_valid && cfg_ready;
  assign look_idx  = host_addr[ADDR_W-1 -: IDX_W];

  aam_cart_latch u_cart (
    .clk(clk), .rst_n(rst_n), .rd4(cart_rd4), .rd5(cart_rd5),
    .cart_eff(cart_eff), .cart_q(cart_mode)
  );

  aam_map_store #(.IDX_W(IDX_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_en(host_strobe), .rd_idx(look_idx),
    .wr_en(wr_en), .wr_idx(cfg_index), .wr_data(cfg_data),
    .rd_data(entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
    end else begin
      s1.valid <= host_strobe;
      s1.addr  <= host_addr;
      s1.cart  <= cart_eff;
    end
  end

  aam_classify #(.MASK_LO(MASK_LO), .MASK_HI(MASK_HI)) u_cls (
    .clk(clk), .rst_n(rst_n), .s1(s1), .entry(entry),
    .res_valid(res_valid), .res_class(res_class), .res_aperture(res_aperture),
    .claim_n(claim_n), .rom_mask_n(rom_mask_n)
  );

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    host_strobe |=> ##1 res_valid); // R2
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (claim_n && rom_mask_n)); // R10
endmodule

// File: tb/sim_aam_decoder.sv
`timescale 1ns/1ps
module sim_aam_decoder;
  localparam int IW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] host_addr = '0;
  logic host_strobe = 0, cart_rd4 = 0, cart_rd5 = 0, cfg_valid = 0;
  logic [IW-1:0] cfg_index = '0;
  logic [7:0] cfg_data = '0;
  logic cfg_ready, res_valid, claim_n, rom_mask_n, cart_mode;
  logic [7:0] res_class;
  logic [3:0] res_aperture;

  always #2.5 clk = ~clk;

  aam_decoder #(.IDX_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_strobe(host_strobe),
    .cart_rd4(cart_rd4), .cart_rd5(cart_rd5), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_index(cfg_index), .cfg_data(cfg_data),
    .res_valid(res_valid), .res_class(res_class), .res_aperture(res_aperture),
    .claim_n(claim_n), .rom_mask_n(rom_mask_n), .cart_mode(cart_mode)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int mmap [1 << IW];
  bit mcart = 0;

  typedef struct { bit v; int cls; int ap; bit cn; bit mn; string tag; } exp_t;
  exp_t pa, pb;

  function automatic exp_t idle_exp();
    exp_t e; e.v = 0; e.cls = 255; e.ap = 0; e.cn = 1; e.mn = 1; e.tag = "R10";
    return e;
  endfunction

  function automatic exp_t predict(int a, bit cart);
    exp_t e; bit win, take;
    e.v = 1;
    e.cls = mmap[a >> (16 - IW)];
    win = (a >= 32768 && a <= 49151);
    take = ((e.cls < 16 && !cart) || (e.cls >= 16 && e.cls < 32)) && !(cart && win);
    e.ap = (e.cls < 16) ? e.cls : 0;
    e.cn = !take;
    e.mn = !(take && a >= 55296 && a <= 57343);
    if (cart && (win || e.cls < 16)) e.tag = "R8";
    else if (a >= 55296 && a <= 57343) e.tag = "R6";
    else if (e.cls < 16) e.tag = "R3";
    else if (e.cls < 32) e.tag = "R4";
    else if (e.cls == 255) e.tag = "R1";
    else e.tag = "R5";
    return e;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic compare();
    chk(res_valid == pa.v, "R2", "res_valid", res_valid, pa.v);
    chk(claim_n == pa.cn, pa.tag, "claim_n", claim_n, pa.cn);
    chk(rom_mask_n == pa.mn, pa.v ? "R6" : "R10", "rom_mask_n", rom_mask_n, pa.mn);
    if (pa.v) begin
      chk(res_class == pa.cls[7:0], pa.tag, "res_class", res_class, pa.cls);
      chk(res_aperture == pa.ap[3:0], "R3", "res_aperture", res_aperture, pa.ap);
    end
    chk(cart_mode == mcart, "R7", "cart_mode", cart_mode, mcart);
  endtask

  task automatic step(bit s, int a, bit r4, bit r5, bit cv, int ci, int cd);
    bit ce;
    @(negedge clk);
    compare();
    host_strobe = s; host_addr = a[15:0]; cart_rd4 = r4; cart_rd5 = r5;
    cfg_valid = cv; cfg_index = ci[IW-1:0]; cfg_data = cd[7:0];
    #1;
    chk(cfg_ready == !s, "R9", "cfg_ready", cfg_ready, !s);
    ce = mcart || r4 || r5;
    pa = pb;
    pb = s ? predict(a, ce) : idle_exp();
    if (cv && !s) mmap[ci] = cd;
    mcart = ce;
  endtask

  task automatic look(int a); step(1, a, 0, 0, 0, 0, 0); endtask
  task automatic wr(int a, int d); step(0, 0, 0, 0, 1, a >> (16 - IW), d); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < (1 << IW); i++) mmap[i] = 255;
    pa = idle_exp(); pb = idle_exp();
    repeat (3) @(negedge clk);
    // R10 reset state before release
    chk(claim_n && rom_mask_n && !res_valid, "R10", "reset outputs", {claim_n, rom_mask_n, res_valid}, 6);
    rst_n = 1;
    // R1 unwritten entries
    look(16'h1000); look(16'h0000); look(16'hFFF0); idle(); idle();
    // loads
    wr(16'h1000, 8'h03); wr(16'hD800, 8'h05); wr(16'h4000, 8'h12);
    wr(16'h5000, 8'h40); wr(16'h8000, 8'h01); wr(16'hA100, 8'h15);
    wr(16'hD900, 8'h18); wr(16'h6000, 8'hFE); wr(16'h7000, 8'h0F);
    // R3 R4 R5 R6 back-to-back
    look(16'h1000); look(16'hD800); look(16'h4000); look(16'h5000);
    look(16'h8000); look(16'hA100); look(16'hD900); look(16'h6000);
    look(16'h7000); idle(); idle();
    // R9 write held off by strobe then looked up next cycle
    step(1, 16'h3000, 0, 0, 1, 16'h3000 >> 4, 8'h07);
    step(0, 0, 0, 0, 1, 16'h3000 >> 4, 8'h07);
    look(16'h3000); idle(); idle();
    // mixed traffic with write interleaving
    seed = 5;
    for (int k = 0; k < 60; k++) begin
      int a;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      a = (seed >> 8) & 16'hFFFF;
      if (k % 3 == 0) wr(a, (seed >> 3) & 8'h1F);
      else look(a);
    end
    idle(); idle();
    // R7 R8 single-cycle cartridge pulse with a window strobe
    step(1, 16'h8000, 0, 1, 0, 0, 0);
    look(16'h1000); look(16'h4000); look(16'hA100); look(16'hD900);
    look(16'h7000); look(16'h5000); look(16'h8000);
    idle(); idle(); idle();
    chk(cart_mode == 1'b1, "R7", "cart_mode sticky", cart_mode, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule